// File: doc/BRIEF.md
# I2C Serial EEPROM Target Interface

This block is the bus-facing logic of a 2048-byte serial memory that acts as an I2C target. The system clock samples SCL and SDA through synchronizers. From those samples the block finds START and STOP conditions and shifts in the device address byte. It acknowledges only bytes whose upper four bits carry its fixed device code. SDA is open-drain, so the block only ever pulls the line low, through an output enable.

The block keeps an 11-bit byte pointer. It serves random, current-address and sequential reads from a behavioural byte array. Each received data byte goes to the write path as a one-cycle strobe that carries the address and the data. In this model the same strobe also updates the array. All eight 256-byte blocks answer on one device: three block-select bits in the device byte pick the block, and the word address byte picks the byte inside it.

Top module: `i2c_mem_target`

## Requirements
- R1: While reset is high, and on the first cycle after it, the block does not drive SDA and does not strobe a write. Reset clears the pointer, so the first current-address read to block 0 returns byte 0x000.
- R2: A device byte whose bits 7..4 differ from 1010 gets no acknowledge. The block then ignores the bus, with SDA released, until the next START.
- R3: Any value of device-byte bits 3..1 is acknowledged, and it becomes pointer bits 10..8. Bit 0 selects the direction: 0 for write, 1 for read.
- R4: In a write transfer the first byte after the device byte sets pointer bits 7..0. Every later byte is acknowledged and produces exactly one single-cycle write strobe with the current pointer and the byte. The pointer then increments.
- R5: A random read (device byte with write, word address, repeated START, device byte with read) returns the byte stored at the addressed location.
- R6: A current-address read returns the byte at the pointer left by the previous access, with bits 10..8 taken from the new device byte.
- R7: During a read, a master ACK makes the block send the next byte. A master NACK ends the read, and the block leaves SDA released.
- R8: The pointer wraps from 0x7FF to 0x000 on both sequential writes and sequential reads.
- R9: A START in the middle of a byte abandons that byte without a write strobe, and the block then expects a device byte.
- R10: After a STOP the block stays idle with SDA released. Bytes clocked without a new START are not acknowledged.
- R11: The SDA drive enable never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 11 | Array address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |

## Verification
The hardest state to reach is the pointer carry across the top of the address space. A write transfer must start at block 7, word 0xFE, and carry on across the wrap. A sequential read with master ACKs must then cross the same boundary. The bench reaches it with a three-byte burst at 0x7FE and then reads the same span back. The other hard case is a START that lands partway through a data byte. The bench clocks four bits by hand and then issues a repeated START. It checks that no strobe appears and that the very next device byte is acknowledged.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam int ADDR_W   = 11;
    localparam int WORD_W   = 8;
    localparam int BLK_W    = ADDR_W - WORD_W;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int CNT_W    = $clog2(WORD_W + 1);
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DEV,
        PH_DEV_ACK,
        PH_WADDR,
        PH_WADDR_ACK,
        PH_WDATA,
        PH_WDATA_ACK,
        PH_RDATA,
        PH_RD_ACK
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic code_ok(input logic [WORD_W-1:0] b);
        return b[WORD_W-1 -: 4] == DEV_CODE;
    endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler
    import i2c_mem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o,
    output logic    scl_o
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_n;
    logic              sda_n;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_n = scl_sh[STAGES-1];
    assign sda_n = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_n;
            sda_q <= sda_n;
        end
    end

    always_comb begin
        ev_o.start = scl_n & scl_q & sda_q & ~sda_n;
        ev_o.stop  = scl_n & scl_q & ~sda_q & sda_n;
        ev_o.rise  = scl_n & ~scl_q;
        ev_o.fall  = ~scl_n & scl_q;
        ev_o.sda   = sda_n;
    end

    assign scl_o = scl_n;

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array
    import i2c_mem_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              sda_oe_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    output phase_t            phase_o
);

    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] rx;
    logic [WORD_W-1:0] tx;
    logic [ADDR_W-1:0] ptr;
    logic              rd_dir;
    logic              m_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            rx         <= '0;
            tx         <= '0;
            ptr        <= '0;
            rd_dir     <= 1'b0;
            m_ack      <= 1'b0;
            sda_oe_o   <= 1'b0;
            wr_valid_o <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
        end else begin
            wr_valid_o <= 1'b0;
            if (ev.start) begin
                phase    <= PH_DEV;
                cnt      <= '0;
                sda_oe_o <= 1'b0;
            end else if (ev.stop) begin
                phase    <= PH_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                unique case (phase)
                    PH_DEV, PH_WADDR, PH_WDATA: begin
                        if (ev.rise && cnt != CNT_W'(WORD_W)) begin
                            rx  <= {rx[WORD_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.fall && cnt == CNT_W'(WORD_W)) begin
                            cnt <= '0;
                            if (phase == PH_DEV) begin
                                if (code_ok(rx)) begin
                                    ptr[ADDR_W-1 -: BLK_W] <= rx[BLK_W:1];
                                    rd_dir   <= rx[0];
                                    sda_oe_o <= 1'b1;
                                    phase    <= PH_DEV_ACK;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end else if (phase == PH_WADDR) begin
                                ptr[WORD_W-1:0] <= rx;
                                sda_oe_o        <= 1'b1;
                                phase           <= PH_WADDR_ACK;
                            end else begin
                                wr_valid_o <= 1'b1;
                                wr_addr_o  <= ptr;
                                wr_data_o  <= rx;
                                ptr        <= ptr + 1'b1;
                                sda_oe_o   <= 1'b1;
                                phase      <= PH_WDATA_ACK;
                            end
                        end
                    end
                    PH_DEV_ACK: begin
                        if (ev.fall) begin
                            if (rd_dir) begin
                                tx       <= rd_data;
                                sda_oe_o <= ~rd_data[WORD_W-1];
                                ptr      <= ptr + 1'b1;
                                cnt      <= '0;
                                phase    <= PH_RDATA;
                            end else begin
                                sda_oe_o <= 1'b0;
                                phase    <= PH_WADDR;
                            end
                        end
                    end
                    PH_WADDR_ACK, PH_WDATA_ACK: begin
                        if (ev.fall) begin
                            sda_oe_o <= 1'b0;
                            phase    <= PH_WDATA;
                        end
                    end
                    PH_RDATA: begin
                        if (ev.fall) begin
                            if (cnt == CNT_W'(WORD_W - 1)) begin
                                sda_oe_o <= 1'b0;
                                cnt      <= '0;
                                phase    <= PH_RD_ACK;
                            end else begin
                                tx       <= {tx[WORD_W-2:0], 1'b0};
                                sda_oe_o <= ~tx[WORD_W-2];
                                cnt      <= cnt + 1'b1;
                            end
                        end
                    end
                    PH_RD_ACK: begin
                        if (ev.rise) begin
                            m_ack <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (m_ack) begin
                                tx       <= rd_data;
                                sda_oe_o <= ~rd_data[WORD_W-1];
                                ptr      <= ptr + 1'b1;
                                cnt      <= '0;
                                phase    <= PH_RDATA;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe_o <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign ptr_o   = ptr;
    assign phase_o = phase;

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o
);

    bus_ev_t           ev;
    logic              scl_now;
    logic [ADDR_W-1:0] ptr;
    logic [WORD_W-1:0] rd_data;
    phase_t            phase;

    i2c_line_sampler #(.STAGES(SYNC_STAGES)) sampler_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev),
        .scl_o (scl_now)
    );

    i2c_target_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .rd_data    (rd_data),
        .ptr_o      (ptr),
        .sda_oe_o   (sda_oe_o),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .phase_o    (phase)
    );

    i2c_mem_array array_i (
        .clk   (clk),
        .we    (wr_valid_o),
        .waddr (wr_addr_o),
        .wdata (wr_data_o),
        .raddr (ptr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
    import i2c_mem_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   scl_seen,
    input logic   start_evt,
    input logic   stop_evt,
    input logic   sda_oe,
    input logic   wr_valid,
    input phase_t phase
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_oe && !wr_valid));

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !sda_oe);

    // R11
    drive_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_seen);

    // R11
    release_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> (!scl_seen || $past(start_evt) || $past(stop_evt)));

endmodule

bind i2c_mem_target i2c_mem_target_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .scl_seen  (scl_now),
    .start_evt (ev.start),
    .stop_evt  (ev.stop),
    .sda_oe    (sda_oe_o),
    .wr_valid  (wr_valid_o),
    .phase     (phase)
);

// File: tb/i2c_mem_target_tb_top.sv
module i2c_mem_target_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic        wr_valid;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int fails = 0;
    int wr_cnt = 0;
    int r11_viol = 0;
    logic [10:0] log_a [16];
    logic [7:0]  log_d [16];
    bit prev_scl = 1'b1;
    bit prev_oe = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_mem_target dut_i (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .wr_valid_o (wr_valid),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    always @(negedge clk) begin
        if (!rst && wr_valid) begin
            if (wr_cnt < 16) begin
                log_a[wr_cnt] = wr_addr;
                log_d[wr_cnt] = wr_data;
            end
            wr_cnt = wr_cnt + 1;
        end
        if (!rst && scl && prev_scl && (sda_oe != prev_oe)) r11_viol = r11_viol + 1;
        prev_scl = scl;
        prev_oe = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; q();
        scl = 1'b1; q();
        m_sda = 1'b0; q();
        scl = 1'b0; q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; q();
        scl = 1'b1; q();
        m_sda = 1'b1; q();
    endtask

    task automatic clock_bit(input bit b);
        repeat (2) @(negedge clk);
        m_sda = b; q();
        scl = 1'b1; q(); q();
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) clock_bit(b[i]);
        repeat (2) @(negedge clk);
        m_sda = 1'b1; q();
        scl = 1'b1; q();
        acked = !sda_line; q();
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        repeat (2) @(negedge clk);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q();
            scl = 1'b1; q();
            d[i] = sda_line; q();
            scl = 1'b0;
        end
        repeat (2) @(negedge clk);
        m_sda = ~mack; q();
        scl = 1'b1; q(); q();
        scl = 1'b0;
        repeat (2) @(negedge clk);
        m_sda = 1'b1;
    endtask

    task automatic t_write_block3();
        bit a; int base = wr_cnt;
        bus_start();
        send_byte(8'hA6, a); chk(a, "R3 block 3 device byte acked", a, 1);
        send_byte(8'h10, a); chk(a, "R4 word address acked", a, 1);
        send_byte(8'h5A, a); chk(a, "R4 data 0 acked", a, 1);
        send_byte(8'hC3, a);
        send_byte(8'h7E, a); chk(a, "R4 data 2 acked", a, 1);
        bus_stop();
        chk(wr_cnt == base + 3, "R4 strobe count", wr_cnt - base, 3);
        chk(log_a[base] == 11'h310 && log_d[base] == 8'h5A, "R3 first strobe addr", log_a[base], 'h310);
        chk(log_a[base+2] == 11'h312 && log_d[base+2] == 8'h7E, "R4 third strobe addr", log_a[base+2], 'h312);
    endtask

    task automatic t_random_read();
        bit a; logic [7:0] d;
        bus_start();
        send_byte(8'hA6, a);
        send_byte(8'h11, a);
        bus_start();
        send_byte(8'hA7, a); chk(a, "R5 read device byte acked", a, 1);
        recv_byte(1'b0, d);
        chk(d == 8'hC3, "R5 random read data", d, 'hC3);
        q();
        chk(sda_line == 1'b1, "R7 SDA released after NACK", sda_line, 1);
        bus_stop();
    endtask

    task automatic t_current_read();
        bit a; logic [7:0] d;
        bus_start();
        send_byte(8'hA7, a);
        recv_byte(1'b0, d);
        chk(d == 8'h7E, "R6 current-address read", d, 'h7E);
        bus_stop();
    endtask

    task automatic t_wrap();
        bit a; logic [7:0] d0, d1, d2; int base = wr_cnt;
        bus_start();
        send_byte(8'hAE, a);
        send_byte(8'hFE, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop();
        chk(log_a[base+2] == 11'h000 && log_d[base+2] == 8'h33, "R8 write pointer wrap", log_a[base+2], 0);
        bus_start();
        send_byte(8'hAE, a);
        send_byte(8'hFE, a);
        bus_start();
        send_byte(8'hAF, a);
        recv_byte(1'b1, d0);
        recv_byte(1'b1, d1);
        recv_byte(1'b0, d2);
        bus_stop();
        chk(d0 == 8'h11 && d1 == 8'h22, "R7 sequential read with ACK", {d0, d1}, 'h1122);
        chk(d2 == 8'h33, "R8 read pointer wrap", d2, 'h33);
    endtask

    task automatic t_bad_code();
        bit a; int base = wr_cnt;
        bus_start();
        send_byte(8'hB0, a); chk(!a, "R2 wrong device code not acked", a, 0);
        send_byte(8'h00, a); chk(!a, "R2 following byte ignored", a, 0);
        bus_stop();
        chk(wr_cnt == base, "R2 no strobe", wr_cnt - base, 0);
    endtask

    task automatic t_abort();
        bit a; logic [7:0] d; int base = wr_cnt;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h40, a);
        for (int i = 0; i < 4; i++) clock_bit(1'b1);
        bus_start();
        chk(wr_cnt == base, "R9 partial byte not written", wr_cnt - base, 0);
        send_byte(8'hA0, a); chk(a, "R9 device byte after restart", a, 1);
        send_byte(8'h40, a);
        send_byte(8'h99, a);
        bus_stop();
        chk(wr_cnt == base + 1 && log_a[base] == 11'h040, "R9 one strobe after restart", wr_cnt - base, 1);
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h40, a);
        bus_start();
        send_byte(8'hA1, a);
        recv_byte(1'b0, d);
        bus_stop();
        chk(d == 8'h99, "R9 readback", d, 'h99);
    endtask

    task automatic t_after_stop();
        bit a; int base = wr_cnt;
        bus_start();
        send_byte(8'hA0, a);
        bus_stop();
        scl = 1'b0; q();
        send_byte(8'hA0, a); chk(!a, "R10 byte without START ignored", a, 0);
        send_byte(8'h55, a); chk(!a, "R10 second byte ignored", a, 0);
        m_sda = 1'b1; q(); scl = 1'b1; q();
        chk(wr_cnt == base, "R10 no strobe", wr_cnt - base, 0);
    endtask

    task automatic t_reset();
        bit a; logic [7:0] d;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(sda_line == 1'b1 && wr_valid == 1'b0, "R1 quiet in reset", {sda_line, wr_valid}, 2);
        rst = 1'b0;
        @(negedge clk);
        chk(sda_oe == 1'b0 && wr_valid == 1'b0, "R1 quiet after reset", {sda_oe, wr_valid}, 0);
        q();
        bus_start();
        send_byte(8'hA1, a);
        recv_byte(1'b0, d);
        bus_stop();
        chk(d == 8'h33, "R1 pointer cleared by reset", d, 'h33);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(sda_line == 1'b1 && wr_valid == 1'b0, "R1 reset state", {sda_line, wr_valid}, 2);
        rst = 1'b0;
        q();
        t_write_block3();
        t_random_read();
        t_current_read();
        t_wrap();
        t_bad_code();
        t_abort();
        t_after_stop();
        t_reset();
        chk(r11_viol == 0, "R11 drive stable while SCL high", r11_viol, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule